// File: doc/BRIEF.md
# Serial Audio Clock Master Generator

This block makes the bit clock and the word clock for a serial audio port that runs as clock master. Its only time base is the master clock. The two pins that later carry the clocks are read as configuration straps while the chip powers up. The same window also reads a flag that tells the block whether the master clock is the low or the high rate of its speed mode. At the end of the window the block freezes that configuration, raises both output enables and starts the clocks.

The bit clock always runs at 64 times the word clock. The straps and the rate flag select how many master clocks make up one bit clock period: 2, 3, 4, 6, 8 or 12. Both clocks keep a 50 % duty cycle. When the division is odd, the bit clock high time is stretched by half a master clock period on the falling master clock edge. The word clock then changes on that same half-cycle edge, so it still switches in step with the falling edge of the bit clock. A one-cycle frame-start pulse, timed by the master clock, marks the start of every frame.

Top module: `audclk_master`

## Requirements
- R1: While reset is applied, and until the enable edge, `bclk_out`, `wclk_out`, `frame_start`, `bclk_oe` and `wclk_oe` are all 0.
- R2: The enable edge is rising `mclk` edge number PWRUP_CYC after reset is released. On that edge the block latches `wclk_strap_in`, `bclk_strap_in` and `mclk_fast`, and both output enables go to 1.
- R3: `wclk_strap_in`=0 selects single speed, which doubles the master clocks per bit clock period. `wclk_strap_in`=1 selects double speed.
- R4: `bclk_strap_in`=0 gives a base of 2 master clocks per bit clock period (the 128x/256x/512x ratio family). `bclk_strap_in`=1 gives a base of 3 (the 192x/384x/768x family).
- R5: `mclk_fast`=1 doubles the master clocks per bit clock period (for example 512x instead of 256x). The word clock ratio is therefore 64 × base × speed factor × rate factor.
- R6: The bit clock first rises one `mclk` cycle after the enable edge. It has a period of D master clocks and is high for D/2 of them, with half-cycle resolution when D is odd.
- R7: The word clock is 0 at enable. It toggles together with every 32nd falling edge of the bit clock, which gives a period of 64 bit clocks at 50 % duty.
- R8: `frame_start` is 1 for exactly one `mclk` cycle, starting at the rising `mclk` edge on which the internal word clock returns to 0.
- R9: Changes on `wclk_strap_in`, `bclk_strap_in` or `mclk_fast` after the enable edge have no effect on either clock.
- R10: Once set, the output enables stay at 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wclk_strap_in | input | 1 | Pad input of the word clock pin, read as the speed strap |
| bclk_strap_in | input | 1 | Pad input of the bit clock pin, read as the ratio family strap |
| mclk_fast | input | 1 | 1 when the master clock is the higher rate of its speed mode |
| bclk_out | output | 1 | Bit clock |
| bclk_oe | output | 1 | Output enable for the bit clock pad |
| wclk_out | output | 1 | Word clock |
| wclk_oe | output | 1 | Output enable for the word clock pad |
| frame_start | output | 1 | One-cycle pulse at the start of each frame |

## Verification
The bench builds the block with PWRUP_CYC=16 instead of the default of 1024. With the short window, all eight strap and rate combinations fit into one run. Each combination gets several complete word clock frames, with every output compared against a model on both master clock edges. The short window also places the latch edge, the first bit clock rise and the odd-ratio half-cycle stretch close enough together that strap changes made just after enable can be seen to have no effect.

// File: rtl/audclk_master.sv
`timescale 1ns/1ps
module audclk_master #(
  parameter int PWRUP_CYC = 1024,
  parameter int SLOT_BITS = 32
) (
  input  logic mclk,
  input  logic rst_n,
  input  logic wclk_strap_in,
  input  logic bclk_strap_in,
  input  logic mclk_fast,
  output logic bclk_out,
  output logic bclk_oe,
  output logic wclk_out,
  output logic wclk_oe,
  output logic frame_start
);
  localparam int PW = $clog2(PWRUP_CYC + 1);
  localparam int SW = $clog2(SLOT_BITS);
  localparam logic [PW-1:0] P_LAST = PW'(PWRUP_CYC - 1);
  localparam logic [SW-1:0] S_LAST = SW'(SLOT_BITS - 1);

  logic [PW-1:0] pcnt;
  logic [SW-1:0] bcnt;
  logic [3:0]    div, dcnt, half;
  logic          run, bclk_q, wclk_q, bclk_n, wclk_n, fs_q, odd, fall;

  function automatic logic [3:0] pick_div(input logic dbl, input logic fam3, input logic fast);
    logic [3:0] d;
    d = fam3 ? 4'd3 : 4'd2;
    if (!dbl) d = d << 1;
    if (fast) d = d << 1;
    return d;
  endfunction

  assign half = div >> 1;
  assign odd  = div[0];
  assign fall = run && (dcnt == half);

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0; run <= 1'b0; div <= 4'd2; dcnt <= '0; bcnt <= '0;
      bclk_q <= 1'b0; wclk_q <= 1'b0; fs_q <= 1'b0;
    end else if (!run) begin
      pcnt <= pcnt + 1'b1;
      if (pcnt == P_LAST) begin
        run <= 1'b1;
        div <= pick_div(wclk_strap_in, bclk_strap_in, mclk_fast);
      end
    end else begin
      dcnt   <= (dcnt == div - 1'b1) ? 4'd0 : dcnt + 1'b1;
      bclk_q <= dcnt < half;
      fs_q   <= fall && (bcnt == S_LAST) && wclk_q;
      if (fall) begin
        bcnt <= (bcnt == S_LAST) ? '0 : bcnt + 1'b1;
        if (bcnt == S_LAST) wclk_q <= ~wclk_q;
      end
    end
  end

  always_ff @(negedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_n <= 1'b0; wclk_n <= 1'b0;
    end else begin
      bclk_n <= bclk_q; wclk_n <= wclk_q;
    end
  end

  assign bclk_out    = bclk_q | (odd & bclk_n);
  assign wclk_out    = odd ? wclk_n : wclk_q;
  assign bclk_oe     = run;
  assign wclk_oe     = run;
  assign frame_start = fs_q;

  AST_QUIET_BEFORE_RUN: assert property (@(posedge mclk) disable iff (!rst_n)
    !run |-> (!bclk_q && !wclk_q && !fs_q)); // R1
  AST_OE_STICKY: assert property (@(posedge mclk) disable iff (!rst_n)
    $past(run) |-> run); // R10
  AST_CFG_FROZEN: assert property (@(posedge mclk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(div)); // R9
  AST_DCNT_RANGE: assert property (@(posedge mclk) disable iff (!rst_n)
    run |-> (dcnt < div)); // R6
  AST_WCLK_ON_FALL: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(wclk_q) |-> $fell(bclk_q)); // R7
  AST_FS_AT_LOW: assert property (@(posedge mclk) disable iff (!rst_n)
    fs_q |-> $fell(wclk_q)); // R8
endmodule

// File: tb/sim_audclk_master.sv
`timescale 1ns/1ps
module sim_audclk_master;
  localparam int PW = 16;
  localparam int SL = 32;
  localparam real TCK = 20.0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_w = 1'b0, s_b = 1'b0, fast = 1'b0;
  logic bclk, bclk_oe, wclk, wclk_oe, fs;
  int edge_n = 0, checks = 0, errs = 0, cur_d = 4;
  bit active = 0, flipped = 0, done = 0;

  always #(TCK/2) clk = ~clk;

  audclk_master #(.PWRUP_CYC(PW), .SLOT_BITS(SL)) u0 (
    .mclk(clk), .rst_n(rst_n), .wclk_strap_in(s_w), .bclk_strap_in(s_b),
    .mclk_fast(fast), .bclk_out(bclk), .bclk_oe(bclk_oe), .wclk_out(wclk),
    .wclk_oe(wclk_oe), .frame_start(fs));

  always @(posedge clk) if (!rst_n) edge_n = 0; else edge_n = edge_n + 1;

  task automatic cmp(input string tag, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s t=%0t actual=%b expected=%b", tag, nm, $time, act, exp);
    end
  endtask

  task automatic sample(input int s);
    int k, t, e, f;
    logic eb, ew, ef, eo;
    if (!active) return;
    k = edge_n - PW;
    t = 2*k + s - 2;
    eo = rst_n && (k >= 0);
    eb = rst_n && (k >= 1) && ((t % (2*cur_d)) < cur_d);
    f  = (t >= cur_d) ? (t - cur_d) / (2*cur_d) + 1 : 0;
    ew = rst_n && (k >= 1) && (((f / SL) % 2) == 1);
    e  = k - 1;
    ef = rst_n && (k >= 1) && ((e % cur_d) == cur_d/2) && (((e / cur_d + 1) % (2*SL)) == 0);
    if (!eo) begin
      cmp("R1", "quiet", {bclk, wclk, fs, bclk_oe, wclk_oe} != 5'b0, 1'b0);
    end else begin
      cmp("R2/R10", "bclk_oe", bclk_oe, 1'b1);
      cmp("R2/R10", "wclk_oe", wclk_oe, 1'b1);
      cmp(flipped ? "R9" : "R6", "bclk", bclk, eb);
      cmp(flipped ? "R9" : "R7", "wclk", wclk, ew);
      cmp("R8", "frame_start", fs, ef);
    end
  endtask

  always @(posedge clk) begin #2; sample(0); end
  always @(negedge clk) begin #2; sample(1); end

  task automatic near(input string tag, input string nm, input realtime a, input realtime x);
    checks++;
    if (a < x - 0.01 || a > x + 0.01) begin
      errs++;
      $display("FAIL %s %s actual=%0.2f expected=%0.2f", tag, nm, a, x);
    end
  endtask

  task automatic run_case(input logic dbl, input logic fam, input logic fst);
    realtime t1, t2, t3;
    active = 0; flipped = 0; rst_n = 0;
    s_w = dbl; s_b = fam; fast = fst;
    cur_d = (fam ? 3 : 2) * (dbl ? 1 : 2) * (fst ? 2 : 1);
    repeat (3) @(posedge clk);
    @(negedge clk); #3;
    active = 1; rst_n = 1;
    @(posedge bclk); t1 = $realtime;
    @(posedge bclk); t2 = $realtime;
    @(negedge bclk); t3 = $realtime;
    near("R3 R4 R5", "bclk period", t2 - t1, cur_d * TCK);
    near("R6", "bclk high", t3 - t2, cur_d * TCK / 2.0);
    #1; flipped = 1; s_w = ~dbl; s_b = ~fam; fast = ~fst;
    @(posedge wclk); t1 = $realtime;
    @(posedge wclk); t2 = $realtime;
    @(negedge wclk); t3 = $realtime;
    near("R7 R9", "wclk period", t2 - t1, 2 * SL * cur_d * TCK);
    near("R7 R9", "wclk high", t3 - t2, SL * cur_d * TCK);
    repeat (10) @(posedge clk);
    @(negedge clk); #5;
    active = 0; rst_n = 0;
  endtask

  task automatic finish_run;
    if (done) return;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 8; c++) run_case(c[2], c[1], c[0]);
    finish_run();
  end

  initial begin
    #(150000 * TCK);
    checks++; errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule